// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the functional clock. Two counters are cascaded. A coarse stage divides by a power of two chosen by a 3-bit code. A fine stage counts the coarse ticks up to the programmed 8-bit value plus a fixed offset of two. One serial clock period therefore lasts `2^code * (div + 2)` functional-clock cycles.

Besides the clock level, the block emits two single-cycle strobes, one on the leading edge and one on the trailing edge of each serial clock period. Shift logic uses these strobes to sample and launch bits. All pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Timing is counted in rising edges of the functional clock. Edge E0 is the first edge at which `en_i` is sampled high. E1, E2, ... follow it while `en_i` stays high.

Top module: `spi_baud_gen`

## Requirements
- R1: While reset is asserted, and right after it, `sck_o` is 0 and both strobes are 0.
- R2: While `en_i` is low, `sck_o` takes the value that `cpol_i` had at the previous edge, and no strobe is raised.
- R3: The coarse stage divides by 2^code, where the code is read as an unsigned 3-bit number. Code 0 gives 1 and code 7 gives 128.
- R4: With F = 2^code and N = div + 2, a leading strobe appears after edge Ek when k mod (F*N) equals floor(N/2)*F. A trailing strobe appears when k mod (F*N) equals 0, with k > 0. No other strobe occurs, so an odd N still gives full periods.
- R5: Each strobe is one cycle wide. After a leading strobe `sck_o` is the inverse of the frame polarity. After a trailing strobe it equals the frame polarity.
- R6: Code, divider and polarity are captured at E0. Changes to them while `en_i` stays high have no effect on strobe timing or on the `sck_o` level.
- R7: When `en_i` falls, `sck_o` returns to idle at the next edge and the counters clear. A following frame starts its timing from zero.
- R8: The leading and trailing strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Frame enable; the rising level starts a frame |
| cpol_i | input | 1 | Idle level of the serial clock |
| pre_code_i | input | 3 | Coarse divider code (factor 2^code) |
| div_val_i | input | 8 | Fine divider value (period adds 2) |
| sck_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on the leading serial clock edge |
| trail_o | output | 1 | One-cycle strobe on the trailing serial clock edge |

## Verification
The bench builds the block with its default widths: a 3-bit code, an 8-bit divider and an offset of two. With these widths the extreme corner is reachable in a short run. Code 7 with divider 255 gives a 32896-cycle period, which exercises both counters at their top values. Divider 0 at code 0 gives the fastest two-cycle period. Odd totals such as 7 are covered, as is a frame whose settings change in mid-flight. A frame cut short is followed by a fresh frame that must restart from zero.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  localparam int unsigned PRE_W_DEF      = 3;
  localparam int unsigned DIV_W_DEF      = 8;
  localparam int unsigned DIV_OFFSET_DEF = 2;

  // terminal count of a power-of-two prescaler, returned one bit wider
  function automatic logic [31:0] pow2_term(input logic [31:0] code);
    logic [31:0] full;
    full = 32'd1 << code;
    return full - 32'd1;
  endfunction
endpackage

// File: rtl/sdiv_capture.sv
module sdiv_capture #(
  parameter int unsigned PRE_W = spi_div_pkg::PRE_W_DEF,
  parameter int unsigned DIV_W = spi_div_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cpol_i,
  input  logic [PRE_W-1:0] code_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             run_o,
  output logic             pol_o,
  output logic [PRE_W-1:0] code_o,
  output logic [DIV_W-1:0] div_o
);
  logic load;
  assign load = en_i && !run_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      pol_o  <= 1'b0;
      code_o <= '0;
      div_o  <= '0;
    end else begin
      run_o <= en_i;
      if (load) begin
        pol_o  <= cpol_i;
        code_o <= code_i;
        div_o  <= div_i;
      end
    end
  end

  // R6: captured settings stay frozen across a running frame
  p_cfg_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> ($stable(code_o) && $stable(div_o) && $stable(pol_o)));
endmodule

// File: rtl/sdiv_prescale.sv
module sdiv_prescale #(
  parameter int unsigned PRE_W = spi_div_pkg::PRE_W_DEF,
  localparam int unsigned PC_W = (1 << PRE_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic [PRE_W-1:0] code_i,
  output logic             tick_o
);
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] term;
  logic [31:0]     term_full;

  assign term_full = spi_div_pkg::pow2_term(32'(code_i));
  assign term      = term_full[PC_W-1:0];
  assign tick_o    = cnt_en_i && (pc == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc <= '0;
    end else if (!cnt_en_i || tick_o) begin
      pc <= '0;
    end else begin
      pc <= pc + 1'b1;
    end
  end

  // R3: the coarse counter never passes its terminal value
  p_pc_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |-> (pc <= term));
  // R7: the coarse counter rests at zero while stopped
  p_pc_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cnt_en_i) |-> (pc == '0));
endmodule

// File: rtl/sdiv_fine.sv
module sdiv_fine #(
  parameter int unsigned DIV_W  = spi_div_pkg::DIV_W_DEF,
  parameter int unsigned OFFSET = spi_div_pkg::DIV_OFFSET_DEF,
  localparam int unsigned CW    = DIV_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             pol_i,
  input  logic             idle_pol_i,
  output logic             sck_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [CW-1:0] dc;
  logic [CW-1:0] nval;
  logic [CW-1:0] half;
  logic          hit_lead;
  logic          hit_trail;

  assign nval      = CW'(div_i) + CW'(OFFSET);
  assign half      = nval >> 1;
  assign hit_lead  = tick_i && (dc == half - 1'b1);
  assign hit_trail = tick_i && (dc == nval - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc      <= '0;
      sck_o   <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!cnt_en_i) begin
      dc      <= '0;
      sck_o   <= idle_pol_i;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else begin
      lead_o  <= hit_lead;
      trail_o <= hit_trail;
      if (tick_i) begin
        dc <= hit_trail ? '0 : dc + 1'b1;
      end
      if (hit_lead) begin
        sck_o <= ~pol_i;
      end else if (hit_trail) begin
        sck_o <= pol_i;
      end
    end
  end

  // R8: the two strobes are exclusive
  p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));
  // R4: the fine counter stays below the period length
  p_dc_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |-> (dc < nval));
  // R5: level after each strobe
  p_lead_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sck_o == ~pol_i));
  p_trail_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sck_o == pol_i));
  p_lead_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |=> !lead_o);
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int unsigned PRE_W  = spi_div_pkg::PRE_W_DEF,
  parameter int unsigned DIV_W  = spi_div_pkg::DIV_W_DEF,
  parameter int unsigned OFFSET = spi_div_pkg::DIV_OFFSET_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cpol_i,
  input  logic [PRE_W-1:0] pre_code_i,
  input  logic [DIV_W-1:0] div_val_i,
  output logic             sck_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic             run;
  logic             pol_q;
  logic [PRE_W-1:0] code_q;
  logic [DIV_W-1:0] div_q;
  logic             cnt_en;
  logic             tick;

  assign cnt_en = run && en_i;

  sdiv_capture #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cpol_i (cpol_i),
    .code_i (pre_code_i),
    .div_i  (div_val_i),
    .run_o  (run),
    .pol_o  (pol_q),
    .code_o (code_q),
    .div_o  (div_q)
  );

  sdiv_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (cnt_en),
    .code_i   (code_q),
    .tick_o   (tick)
  );

  sdiv_fine #(.DIV_W(DIV_W), .OFFSET(OFFSET)) u_fine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (cnt_en),
    .tick_i     (tick),
    .div_i      (div_q),
    .pol_i      (pol_q),
    .idle_pol_i (cpol_i),
    .sck_o      (sck_o),
    .lead_o     (lead_o),
    .trail_o    (trail_o)
  );

  // R2: disabled means idle level from last cycle's polarity, no strobes
  p_idle_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(en_i)) |-> (sck_o == $past(cpol_i) && !lead_o && !trail_o));
  // R5: during a frame the clock only moves together with a strobe
  p_sck_moves_with_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_en) && (sck_o != $past(sck_o))) |-> (lead_o || trail_o));
  // R7: dropping enable ends all strobes at the next edge
  p_stop_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |=> (!lead_o && !trail_o));
endmodule

// File: tb/spi_baud_gen_tb_top.sv
module spi_baud_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cpol = 1'b0;
  logic [2:0] code = '0;
  logic [7:0] div = '0;
  logic       sck, lead, trail;

  int errors = 0;
  int checks = 0;

  typedef struct { int k; bit is_lead; string req; } ev_t;
  ev_t expq[$];
  int  kcnt = 0;
  bit  en_prev = 1'b0;
  bit  pol_exp = 1'b0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  spi_baud_gen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .cpol_i     (cpol),
    .pre_code_i (code),
    .div_val_i  (div),
    .sck_o      (sck),
    .lead_o     (lead),
    .trail_o    (trail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // edge index since frame start (E0 = first edge with enable high)
  always @(posedge clk) begin
    if (en) kcnt = en_prev ? kcnt + 1 : 0;
    en_prev = en;
  end

  // monitor: pops expected strobes and compares
  always @(negedge clk) begin
    if (rst_n && (lead || trail)) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4", "unexpected strobe at k", kcnt, -1);
      end else begin
        ev_t e;
        e = expq.pop_front();
        chk(e.k == kcnt, e.req, "strobe edge index", kcnt, e.k);
        chk(lead == e.is_lead, e.req, "strobe kind lead", int'(lead), int'(e.is_lead));
        chk(sck == (lead ? ~pol_exp : pol_exp), "R5", "sck level after strobe",
            int'(sck), int'(lead ? ~pol_exp : pol_exp));
      end
    end
  end

  // driver: computes expected strobes, runs a frame, optionally alters inputs mid-frame
  task automatic run_frame(input int c, input int d, input bit p, input int n,
                           input int chg_at, input int c2, input int d2, input bit p2,
                           input string req);
    int f, nn, h, per;
    f = 1 << c; nn = d + 2; h = nn / 2; per = f * nn;
    for (int k = 1; k <= n; k++) begin
      ev_t e;
      e.req = req;
      if (k % per == 0) begin e.k = k; e.is_lead = 1'b0; expq.push_back(e); end
      else if (k % per == h * f) begin e.k = k; e.is_lead = 1'b1; expq.push_back(e); end
    end
    pol_exp = p;
    @(negedge clk);
    code = 3'(c); div = 8'(d); cpol = p; en = 1'b1;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i == chg_at) begin code = 3'(c2); div = 8'(d2); cpol = p2; end
    end
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(expq.size() == 0, req, "expected strobes left over", expq.size(), 0);
    expq.delete();
    chk(sck == cpol && !lead && !trail, "R7", "idle after frame sck", int'(sck), int'(cpol));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sck == 1'b0, "R1", "sck in reset", int'(sck), 0);
    chk(!lead && !trail, "R1", "strobes in reset", int'(lead || trail), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck == 1'b0 && !lead && !trail, "R1", "state after reset", int'(sck), 0);
    // R2: idle level follows polarity one edge later
    cpol = 1'b1;
    @(negedge clk);
    chk(sck == 1'b1, "R2", "idle follows cpol high", int'(sck), 1);
    chk(!lead && !trail, "R2", "no strobes while disabled", int'(lead || trail), 0);
    cpol = 1'b0;
    @(negedge clk);
    chk(sck == 1'b0, "R2", "idle follows cpol low", int'(sck), 0);
    // R4 fastest period, divider boundary 0
    run_frame(0, 0, 1'b0, 10, -1, 0, 0, 1'b0, "R4");
    // R3 factor 2, odd N=3, polarity high
    run_frame(1, 1, 1'b1, 20, -1, 0, 0, 1'b0, "R3");
    // R4 odd total 7 with factor 8
    run_frame(3, 5, 1'b0, 120, -1, 0, 0, 1'b0, "R4");
    // R3 top code and top divider
    run_frame(7, 255, 1'b1, 33000, -1, 0, 0, 1'b0, "R3");
    // R6 settings changed mid-frame are ignored
    run_frame(2, 2, 1'b0, 40, 5, 0, 0, 1'b1, "R6");
    // R7 frame cut short, then a fresh frame restarts from zero
    run_frame(2, 3, 1'b1, 10, -1, 0, 0, 1'b0, "R7");
    run_frame(2, 3, 1'b1, 25, -1, 0, 0, 1'b0, "R7");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule